// File: doc/BRIEF.md
# Key-Protected Register File with One-Shot Unlock

This block is a small bank of control registers reached over an APB slave port with a 32-bit data path. Some registers are 32 bits wide. Others are 64 bits wide and appear as two adjacent 32-bit words. Every write is guarded by a gate that comes out of reset closed. Software opens the gate with a secure, full-width write of a magic byte to a key word. The gate then admits exactly one protected write and closes itself again.

The gate makes one exception for 64-bit registers. If the admitted write is a secure, full-strobe write to one half of a 64-bit register, the gate stays open for one more write. That write must go to the other half of the same register, and the halves may arrive in either order. This lets an interconnect split a 64-bit store into two 32-bit beats without a second unlock.

Non-secure traffic has no effect on the gate or on any register. The security attribute is APB PPROT bit 1, where 1 means non-secure. Reads work whether the gate is open or closed.

Top module: `keyed_regfile`

## Requirements
- R1: After reset the gate is closed, every register reads 0x00000000, and the key word reads 0x00000000.
- R2: While the gate is closed, a write to any address other than the key word leaves all registers unchanged.
- R3: A key write opens the gate only when all of the following hold: it is secure (PPROT[1]=0), PSTRB=4'hF, and PWDATA[7:0]=0xBE. PWDATA[31:8] is ignored.
- R4: The key word reads 0x000000BE while the gate is open, including while a paired-half window is pending. It reads 0x00000000 while the gate is closed.
- R5: While the gate is open with no window pending, a secure write to any non-key address is applied through its byte strobes (PSTRB bit b enables byte b). The gate then closes. A write to an unmapped address changes no register but still closes the gate.
- R6: While the gate is open, a key write that meets the R3 criteria leaves it open with no window pending. Any other secure key write closes it.
- R7: A non-secure write (PPROT[1]=1) changes no register and does not change the gate state. A non-secure read returns 0x00000000.
- R8: With the gate open, a secure full-strobe write to the upper half of a 64-bit register, followed by the same kind of write to its lower half, updates both halves. The gate then closes.
- R9: The lower-then-upper order behaves the same way as R8.
- R10: While a paired-half window is pending, a secure non-key write that does not target the other half of the same register with full strobes is ignored. That includes a write to the same half again. The write then closes the gate.
- R11: A write to a 64-bit half with partial strobes is applied, but it opens no window. The next write to the other half is ignored.
- R12: The address map is fixed. The key word is at 0x00. The lower half of 64-bit register k is at 0x08+8k and its upper half at 0x0C+8k. The 32-bit registers follow, 4 bytes apart (by default 0x18 and 0x1C). Any other address reads 0x00000000. PREADY is always 1 and PSLVERR is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | ADDR_W | APB byte address |
| pprot | input | 3 | APB protection; bit 1 set marks a non-secure access |
| pstrb | input | 4 | APB byte write strobes |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |

## Verification
A wrong gate state shows up at the ports right away: the key word reads back 0xBE or 0 in the very next read, so each step of the sequence is checked by reading the key after it. A gate that closes too late or too early shows up one write later. A register that should have stayed fixed reads back the stored value, and a pair that should have been admitted reads back stale data. The bench therefore follows every gated write with read-backs of the target register, of the other half of the pair, and of the key word. It covers both pair orders, mismatched and repeated halves, partial strobes, key writes inside a pending window, and non-secure traffic.

// File: rtl/kreg_pkg.sv
package kreg_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int IDX_W  = 4;            // up to 16 registers of each kind
    localparam logic [7:0] KEY_BYTE = 8'hBE;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_OPEN   = 2'd1,
        GATE_PAIR   = 2'd2
    } gate_state_e;

    // Decoded address
    typedef struct packed {
        logic             key;
        logic             wide;
        logic             narrow;
        logic [IDX_W-1:0] idx;
        logic             upper;
    } dec_t;

    // First half written while a paired window is pending
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             upper;
    } pair_rec_t;

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/kreg_decode.sv
module kreg_decode
    import kreg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int WIDE_BASE   = 8;
    localparam int NARROW_BASE = WIDE_BASE + 8 * NUM_WIDE;

    always_comb begin
        dec = '0;
        if (addr == '0) dec.key = 1'b1;
        for (int i = 0; i < NUM_WIDE; i++) begin
            if (addr == ADDR_W'(WIDE_BASE + 8 * i)) begin
                dec.wide  = 1'b1;
                dec.idx   = IDX_W'(i);
                dec.upper = 1'b0;
            end
            if (addr == ADDR_W'(WIDE_BASE + 8 * i + 4)) begin
                dec.wide  = 1'b1;
                dec.idx   = IDX_W'(i);
                dec.upper = 1'b1;
            end
        end
        for (int j = 0; j < NUM_NARROW; j++) begin
            if (addr == ADDR_W'(NARROW_BASE + 4 * j)) begin
                dec.narrow = 1'b1;
                dec.idx    = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/kreg_gate.sv
module kreg_gate
    import kreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_go,     // secure write in access phase
    input  logic        full,
    input  logic        key_ok,
    input  dec_t        dec,
    output logic        commit,
    output gate_state_e state_q
);
    gate_state_e state_d;
    pair_rec_t   rec_q, rec_d;
    logic        pair_match;
    logic        unused_dec;

    assign unused_dec = dec.narrow;
    assign pair_match = dec.wide && full && (dec.idx == rec_q.idx)
                        && (dec.upper != rec_q.upper);

    always_comb begin
        state_d = state_q;
        rec_d   = rec_q;
        commit  = 1'b0;
        if (wr_go) begin
            if (dec.key) begin
                state_d = (full && key_ok) ? GATE_OPEN : GATE_LOCKED;
            end else begin
                case (state_q)
                    GATE_OPEN: begin
                        commit = 1'b1;
                        if (dec.wide && full) begin
                            state_d = GATE_PAIR;
                            rec_d   = '{idx: dec.idx, upper: dec.upper};
                        end else begin
                            state_d = GATE_LOCKED;
                        end
                    end
                    GATE_PAIR: begin
                        commit  = pair_match;
                        state_d = GATE_LOCKED;
                    end
                    default: state_d = GATE_LOCKED;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_LOCKED;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
        end
    end
endmodule

// File: rtl/kreg_bank.sv
module kreg_bank
    import kreg_pkg::*;
#(
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    input  logic              rd_en,
    input  logic              unlocked,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_WIDE-1:0][DATA_W-1:0]   lo_vec, hi_vec;
    logic [NUM_NARROW-1:0][DATA_W-1:0] nar_vec;

    for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
        logic [DATA_W-1:0] lo_q, hi_q;
        logic              hit;
        assign hit = commit && dec.wide && (dec.idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (dec.upper) hi_q <= merge_bytes(hi_q, wdata, strb);
                else           lo_q <= merge_bytes(lo_q, wdata, strb);
            end
        end
        assign lo_vec[i] = lo_q;
        assign hi_vec[i] = hi_q;
    end

    for (genvar j = 0; j < NUM_NARROW; j++) begin : g_narrow
        logic [DATA_W-1:0] val_q;
        logic              hit;
        assign hit = commit && dec.narrow && (dec.idx == IDX_W'(j));
        always_ff @(posedge clk) begin
            if (rst)      val_q <= '0;
            else if (hit) val_q <= merge_bytes(val_q, wdata, strb);
        end
        assign nar_vec[j] = val_q;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (dec.key) begin
                rdata = unlocked ? DATA_W'(KEY_BYTE) : '0;
            end
            for (int i = 0; i < NUM_WIDE; i++) begin
                if (dec.wide && dec.idx == IDX_W'(i))
                    rdata = dec.upper ? hi_vec[i] : lo_vec[i];
            end
            for (int j = 0; j < NUM_NARROW; j++) begin
                if (dec.narrow && dec.idx == IDX_W'(j))
                    rdata = nar_vec[j];
            end
        end
    end
endmodule

// File: rtl/keyed_regfile.sv
module keyed_regfile
    import kreg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [2:0]        pprot,
    input  logic [3:0]        pstrb,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr
);
    dec_t        dec;
    gate_state_e state_q;
    logic        commit, wr_go, rd_en, full, key_ok, unlocked;
    logic        unused_prot;

    assign unused_prot = pprot[2] ^ pprot[0];
    assign wr_go    = psel && penable && pwrite && !pprot[1];
    assign rd_en    = psel && !pwrite && !pprot[1];
    assign full     = &pstrb;
    assign key_ok   = (pwdata[7:0] == KEY_BYTE);
    assign unlocked = (state_q != GATE_LOCKED);
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;

    kreg_decode #(
        .ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW)
    ) u_decode (
        .addr(paddr), .dec(dec)
    );

    kreg_gate u_gate (
        .clk(clk), .rst(rst), .wr_go(wr_go), .full(full), .key_ok(key_ok),
        .dec(dec), .commit(commit), .state_q(state_q)
    );

    kreg_bank #(
        .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW)
    ) u_bank (
        .clk(clk), .rst(rst), .commit(commit), .dec(dec), .wdata(pwdata),
        .strb(pstrb), .rd_en(rd_en), .unlocked(unlocked), .rdata(prdata)
    );
endmodule

// File: rtl/kreg_checker.sv
module kreg_checker
    import kreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [2:0]        pprot,
    input logic [3:0]        pstrb,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input gate_state_e       state,
    input logic              commit
);
    logic wr, sec, to_key, good_key;
    assign wr       = psel && penable && pwrite;
    assign sec      = !pprot[1];
    assign to_key   = (paddr == '0);
    assign good_key = (pstrb == 4'hF) && (pwdata[7:0] == 8'hBE);

    // R1
    reset_locks_chk: assert property (@(posedge clk)
        rst |=> state == GATE_LOCKED);

    // R2
    locked_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && state == GATE_LOCKED && !to_key) |-> !commit);

    // R3
    key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sec && to_key && good_key) |=> state == GATE_OPEN);

    // R6
    key_fail_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sec && to_key && !good_key) |=> state == GATE_LOCKED);

    // R7
    nonsecure_state_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sec) |=> $stable(state));

    // R7
    nonsecure_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sec) |-> !commit);

    // R5
    partial_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sec && !to_key && state == GATE_OPEN && pstrb != 4'hF)
        |=> state == GATE_LOCKED);

    // R10
    pair_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sec && !to_key && state == GATE_PAIR) |=> state == GATE_LOCKED);

    // R4
    key_read_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && sec && to_key)
        |-> prdata == ((state != GATE_LOCKED) ? 32'h0000_00BE : 32'h0));
endmodule

bind keyed_regfile kreg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pprot(pprot), .pstrb(pstrb), .pwdata(pwdata),
    .prdata(prdata), .state(state_q), .commit(commit)
);

// File: tb/keyed_regfile_test.sv
`timescale 1ns/1ps
module keyed_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [2:0]  pprot = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] KEY = 8'h00, W0L = 8'h08, W0H = 8'h0C,
                           W1L = 8'h10, W1H = 8'h14, N0 = 8'h18, N1 = 8'h1C;

    always #2.5 clk = ~clk;

    keyed_regfile uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pprot(pprot), .pstrb(pstrb), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] s = 4'hF, input bit ns = 1'b0);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = a; pwdata = d; pstrb = s; pprot = ns ? 3'b010 : 3'b000;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = '0;
    endtask

    task automatic apb_read(input logic [7:0] a, input logic [31:0] e,
                            input string tag, input bit ns = 1'b0);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0;
        paddr = a; pprot = ns ? 3'b010 : 3'b000;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic unlock();
        apb_write(KEY, 32'h0000_00BE);
    endtask

    // Monitor: pops one expected item per completed read
    initial begin
        forever begin
            @(posedge clk);
            if (psel && penable && !pwrite && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (prdata !== e || pready !== 1'b1 || pslverr !== 1'b0) begin
                    mismatched++;
                    $display("FAIL %s: prdata=%h pready=%b pslverr=%b expected prdata=%h pready=1 pslverr=0",
                             t, prdata, pready, pslverr, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        apb_read(KEY, 32'h0, "R1 key after reset");
        apb_read(N0,  32'h0, "R1 narrow after reset");
        apb_read(W0H, 32'h0, "R1 wide after reset");

        apb_write(N0, 32'h1111_2222);
        apb_read(N0, 32'h0, "R2 locked write ignored");

        apb_write(KEY, 32'h0000_00BE, 4'hF, 1'b1);
        apb_read(KEY, 32'h0, "R7 non-secure key write");
        apb_write(KEY, 32'h0000_00BE, 4'h1);
        apb_read(KEY, 32'h0, "R3 partial strobe key");
        apb_write(KEY, 32'h0000_00BF);
        apb_read(KEY, 32'h0, "R3 wrong key byte");
        apb_write(KEY, 32'hFFFF_FFBE);
        apb_read(KEY, 32'h0000_00BE, "R3 R4 unlock with upper bits set");

        apb_write(N0, 32'h0000_DEAD, 4'hF, 1'b1);
        apb_read(N0, 32'h0, "R7 non-secure write no update");
        apb_read(KEY, 32'h0000_00BE, "R7 non-secure write keeps state");
        apb_read(KEY, 32'h0, "R7 non-secure read returns zero", 1'b1);

        apb_write(N0, 32'hAABB_CCDD, 4'h3);
        apb_read(KEY, 32'h0, "R5 relock after write");
        apb_read(N0, 32'h0000_CCDD, "R5 byte strobes applied");
        apb_write(N1, 32'h5555_5555);
        apb_read(N1, 32'h0, "R2 second write after relock ignored");
        unlock();
        apb_write(N1, 32'hFEED_F00D);
        apb_read(N1, 32'hFEED_F00D, "R5 full write narrow");

        unlock();
        apb_write(KEY, 32'h0000_0000);
        apb_read(KEY, 32'h0, "R6 bad key relocks");
        unlock();
        unlock();
        apb_read(KEY, 32'h0000_00BE, "R6 good key keeps open");

        apb_write(W0H, 32'h1234_5678);
        apb_read(KEY, 32'h0000_00BE, "R4 key open during pair window");
        apb_write(W0L, 32'h9ABC_DEF0);
        apb_read(W0H, 32'h1234_5678, "R8 upper half first");
        apb_read(W0L, 32'h9ABC_DEF0, "R8 lower half second");
        apb_read(KEY, 32'h0, "R8 relock after pair");
        apb_write(W0H, 32'hFFFF_FFFF);
        apb_read(W0H, 32'h1234_5678, "R8 third write ignored");

        unlock();
        apb_write(W1L, 32'h0102_0304);
        apb_write(W1H, 32'h0506_0708);
        apb_read(W1L, 32'h0102_0304, "R9 lower half first");
        apb_read(W1H, 32'h0506_0708, "R9 upper half second");
        apb_read(KEY, 32'h0, "R9 relock after pair");

        unlock();
        apb_write(W0L, 32'h1111_1111);
        apb_write(W1L, 32'h2222_2222);
        apb_read(W0L, 32'h1111_1111, "R10 first half taken");
        apb_read(W1L, 32'h0102_0304, "R10 other register ignored");
        apb_read(KEY, 32'h0, "R10 mismatch relocks");
        unlock();
        apb_write(W0H, 32'hAAAA_0000);
        apb_write(W0H, 32'hBBBB_0000);
        apb_read(W0H, 32'hAAAA_0000, "R10 same half twice ignored");

        unlock();
        apb_write(W0L, 32'h7777_0000, 4'hC);
        apb_write(W0H, 32'h9999_9999);
        apb_read(W0L, 32'h7777_1111, "R11 partial wide write applied");
        apb_read(W0H, 32'hAAAA_0000, "R11 no window after partial");
        apb_read(KEY, 32'h0, "R11 locked after partial");

        unlock();
        apb_write(W1L, 32'hCAFE_0001);
        unlock();
        apb_read(KEY, 32'h0000_00BE, "R6 good key inside pair window");
        apb_write(W1H, 32'h0BAD_0002);
        apb_write(N0, 32'h0000_0012);
        apb_read(W1H, 32'h0BAD_0002, "R6 fresh write after rekey");
        apb_read(N0, 32'h0000_CCDD, "R10 narrow in window ignored");
        apb_read(KEY, 32'h0, "R10 locked after window");

        apb_read(8'h04, 32'h0, "R12 unmapped 0x04");
        apb_read(8'h40, 32'h0, "R12 unmapped 0x40");
        unlock();
        apb_write(8'h40, 32'hFFFF_FFFF);
        apb_read(KEY, 32'h0, "R5 unmapped write relocks");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R12: reads completed=%0d expected all queued", compared);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule